// File: doc/BRIEF.md
# Serializer Link State Controller

This block handles framing and link state for a transmitter that turns 10-bit parallel words into a serial stream. It runs on the bit-rate clock. In the last bit cycle of every frame it raises a word strobe, and the source presents the next word during that cycle. The block wraps each word in a 12-bit frame and shifts the frame out one bit per clock. Frames follow each other with no gap.

The serial output has an enable that stays low until the lock input reports that the clock source is stable. If either of two sync-request inputs is high when a frame is loaded, the block sends a sync frame in place of user data. A sync frame is a fixed run of six ones followed by six zeros, and it lets a receiver acquire the link within a bounded time. Losing lock moves the block into a resynchronization state. Power-down overrides everything. A tri-state control silences the output without disturbing the framing.

Top module: `ser_link_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `link_state` reads 0 (initialization) and `ser_oe` is 0.
- R2: Before `lock` is first seen high, `ser_oe` stays 0 and `link_state` stays 0. The first rising clock edge that sees `lock` high sets `link_state` to 1 (transfer), and `word_tick` is high in the cycle that follows.
- R3: A data frame is 12 bits sent LSB first: a start bit of 1, then `din[0]` through `din[9]`, then a stop bit of 0. `word_tick` is high in the last bit cycle of each frame, and `din` is sampled on the clock edge that ends that cycle. The first bit of the new frame appears in the next cycle. Frames repeat every 12 cycles.
- R4: If `sync_a` or `sync_b` is high on the edge that loads a frame, that frame is six 1 bits followed by six 0 bits.
- R5: A change on `sync_a` or `sync_b` in the middle of a frame does not alter that frame. Only the next frame load picks it up.
- R6: If `lock` is low on a clock edge while `link_state` is 1, `link_state` becomes 2 (resynchronization) and `ser_oe` becomes 0 after that edge. Once `lock` is high again, `link_state` returns to 1 and a fresh frame begins, as in R2.
- R7: `pwr_dn` takes priority over all other inputs. After any edge that sees it high, `link_state` is 3, `ser_oe` is 0 and `ser_out` is 0 (the shift register is cleared). The first edge with `pwr_dn` low returns `link_state` to 0.
- R8: `tri_en` high forces `ser_oe` low in the same cycle and leaves `link_state` unchanged. After `tri_en` is released, `ser_oe` stays low until the next frame load at which `tri_en` is low, and then comes back at that frame's start bit.
- R9: `ser_oe` is high only in state 1, and only while `lock` was high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Parallel word, sampled at the frame load |
| lock | input | 1 | Clock source lock status |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| pwr_dn | input | 1 | Power-down, highest priority |
| tri_en | input | 1 | Output tri-state request |
| word_tick | output | 1 | High in the last bit cycle of each frame (word strobe) |
| ser_out | output | 1 | Serial bit |
| ser_oe | output | 1 | Output enable for the serial driver |
| link_state | output | 2 | 0 init, 1 transfer, 2 resync, 3 power-down |

## Verification
The assertions check several rules on every cycle. A low `lock` removes the enable on the next cycle. Power-down reaches state 3 with the output silent. `tri_en` keeps the enable low. Every frame load is followed by a start bit, an enabled frame ends in a stop bit, and word strobes arrive exactly 12 cycles apart while the link stays up. Some behaviours only the bench's scenarios can show: that deserialized data words match what was sent, that sync frames carry the six-and-six pattern, that a sync change in mid-frame is deferred, and that the enable returns only at a frame boundary after tri-state or relock.

// File: rtl/ser_link_ctl.sv
module ser_link_ctl #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              lock,
  input  logic              sync_a,
  input  logic              sync_b,
  input  logic              pwr_dn,
  input  logic              tri_en,
  output logic              word_tick,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [1:0]        link_state
);
  localparam int FRAME_LEN = WORD_W + 2;
  localparam int HALF      = FRAME_LEN / 2;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
  localparam logic [FRAME_LEN-1:0] SYNC_PAT = {{(FRAME_LEN-HALF){1'b0}}, {HALF{1'b1}}};

  typedef enum logic [1:0] {
    S_INIT   = 2'd0,
    S_XFER   = 2'd1,
    S_RESYNC = 2'd2,
    S_PDN    = 2'd3
  } state_t;

  state_t                 state;
  logic [CW-1:0]          cnt;
  logic [FRAME_LEN-1:0]   shreg;
  logic                   mute;
  logic [FRAME_LEN-1:0]   next_frame;

  assign word_tick  = (state == S_XFER) && (cnt == LAST);
  assign next_frame = (sync_a || sync_b) ? SYNC_PAT : {1'b0, din, 1'b1};
  assign ser_out    = shreg[0];
  assign ser_oe     = (state == S_XFER) && !mute && !tri_en;
  assign link_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_INIT;
      cnt   <= LAST;
      shreg <= '0;
      mute  <= 1'b1;
    end else if (pwr_dn) begin
      state <= S_PDN;
      cnt   <= LAST;
      shreg <= '0;
      mute  <= 1'b1;
    end else begin
      case (state)
        S_PDN: begin
          state <= S_INIT;
        end
        S_INIT, S_RESYNC: begin
          if (lock) state <= S_XFER;
          cnt   <= LAST;
          shreg <= '0;
          mute  <= 1'b1;
        end
        default: begin
          if (!lock) begin
            state <= S_RESYNC;
            cnt   <= LAST;
            shreg <= '0;
            mute  <= 1'b1;
          end else if (cnt == LAST) begin
            shreg <= next_frame;
            cnt   <= '0;
            mute  <= tri_en;
          end else begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
            if (tri_en) mute <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ser_link_ctl_chk.sv
module ser_link_ctl_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] din,
  input logic              lock,
  input logic              sync_a,
  input logic              sync_b,
  input logic              pwr_dn,
  input logic              tri_en,
  input logic              word_tick,
  input logic              ser_out,
  input logic              ser_oe,
  input logic [1:0]        link_state
);
  localparam int FRAME_LEN = WORD_W + 2;

  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (link_state != 2'd1 || pwr_dn || !lock) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 8'd1;
    end
  end

  p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !ser_oe);

  p_oe_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> (link_state == 2'd1));

  p_pdn_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (link_state == 2'd3 && !ser_oe && !ser_out));

  p_tri_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tri_en |-> !ser_oe);

  p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && lock && !pwr_dn) |=> ser_out);

  p_stop_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && ser_oe) |-> !ser_out);

  p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && seen) |-> (gap == 8'(FRAME_LEN - 1)));
endmodule

bind ser_link_ctl ser_link_ctl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .lock(lock),
  .sync_a(sync_a), .sync_b(sync_b), .pwr_dn(pwr_dn), .tri_en(tri_en),
  .word_tick(word_tick), .ser_out(ser_out), .ser_oe(ser_oe),
  .link_state(link_state)
);

// File: tb/ser_link_ctl_test.sv
module ser_link_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] din;
  logic       lock, sync_a, sync_b, pwr_dn, tri_en;
  logic       word_tick, ser_out, ser_oe;
  logic [1:0] link_state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ser_link_ctl uut (
    .clk(clk), .rst_n(rst_n), .din(din), .lock(lock),
    .sync_a(sync_a), .sync_b(sync_b), .pwr_dn(pwr_dn), .tri_en(tri_en),
    .word_tick(word_tick), .ser_out(ser_out), .ser_oe(ser_oe),
    .link_state(link_state)
  );

  // {sync_a, sync_b, din}
  localparam logic [11:0] VEC [0:7] = '{
    12'h000, 12'h3FF, 12'h2AA, 12'h155,
    12'h800, 12'h733, 12'hC1F, 12'h201
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [9:0] w, input logic s);
    if (s) return 12'b000000_111111;
    return {1'b0, w, 1'b1};
  endfunction

  task automatic wait_tick();
    int n = 0;
    while (!word_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(word_tick == 1'b1, "R3 tick", int'(word_tick), 1);
  endtask

  // Starts at a negedge with word_tick high, ends at the next such negedge.
  task automatic run_frame(input logic [9:0] w, input logic sa, input logic sb,
                           input bit flip, input string req);
    logic [11:0] e;
    chk(word_tick == 1'b1, req, int'(word_tick), 1);
    din = w; sync_a = sa; sync_b = sb;
    e = exp_frame(w, sa | sb);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(ser_oe && (ser_out == e[i]), req, int'({ser_oe, ser_out}), int'({1'b1, e[i]}));
      if (flip && i == 5) sync_a = ~sa;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = '0; lock = 1'b0; sync_a = 1'b0; sync_b = 1'b0;
    pwr_dn = 1'b0; tri_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(link_state == 2'd0 && !ser_oe, "R1", int'({link_state, ser_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_state == 2'd0 && !ser_oe, "R1", int'({link_state, ser_oe}), 0);

    // R2: no enable without lock
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!ser_oe && link_state == 2'd0, "R2", int'({link_state, ser_oe}), 0);
    end
    lock = 1'b1;
    @(negedge clk);
    chk(link_state == 2'd1 && word_tick, "R2", int'({link_state, word_tick}), 3);

    // R3/R4 table walk
    for (int k = 0; k < 8; k++)
      run_frame(VEC[k][9:0], VEC[k][11], VEC[k][10], 1'b0,
                (VEC[k][11] | VEC[k][10]) ? "R4" : "R3");

    // R5: mid-frame sync change is deferred, both directions
    run_frame(10'h0F3, 1'b0, 1'b0, 1'b1, "R5");
    run_frame(10'h3C1, 1'b1, 1'b0, 1'b1, "R5");
    run_frame(10'h155, 1'b0, 1'b0, 1'b0, "R5");

    // R8: tri-state mid-frame
    din = 10'h2D4; sync_a = 1'b0;
    repeat (3) @(negedge clk);
    tri_en = 1'b1;
    #1;
    chk(!ser_oe, "R8", int'(ser_oe), 0);
    @(negedge clk);
    wait_tick();
    chk(link_state == 2'd1 && !ser_oe, "R8", int'({link_state, ser_oe}), 2);
    repeat (3) @(negedge clk);
    tri_en = 1'b0;
    #1;
    chk(!ser_oe, "R8", int'(ser_oe), 0);
    @(negedge clk);
    chk(!ser_oe, "R8", int'(ser_oe), 0);
    wait_tick();
    run_frame(10'h1E7, 1'b0, 1'b0, 1'b0, "R8");

    // R6: lock loss mid-frame
    din = 10'h0AA;
    repeat (4) @(negedge clk);
    lock = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(link_state == 2'd2 && !ser_oe, "R6", int'({link_state, ser_oe}), 4);
    end
    lock = 1'b1;
    @(negedge clk);
    chk(link_state == 2'd1 && word_tick, "R6", int'({link_state, word_tick}), 3);
    run_frame(10'h333, 1'b0, 1'b0, 1'b0, "R6");

    // R7: power-down with lock and sync held high
    din = 10'h3FF;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b1; sync_a = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(link_state == 2'd3 && !ser_oe && !ser_out, "R7",
          int'({link_state, ser_oe, ser_out}), 12);
    end
    pwr_dn = 1'b0; sync_a = 1'b0;
    @(negedge clk);
    chk(link_state == 2'd0 && !ser_oe, "R7", int'({link_state, ser_oe}), 0);
    @(negedge clk);
    chk(link_state == 2'd1 && word_tick, "R7", int'({link_state, word_tick}), 3);
    run_frame(10'h201, 1'b0, 1'b0, 1'b0, "R7");
    run_frame(10'h000, 1'b0, 1'b1, 1'b0, "R4");

    // R9: no enable in resync even with tri_en low
    lock = 1'b0;
    @(negedge clk);
    chk(!ser_oe && link_state == 2'd2, "R9", int'({link_state, ser_oe}), 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule